// File: doc/BRIEF.md
# Decoupled Instruction Fetch Unit

This unit keeps an execution stage supplied with 16-bit instructions. Fetch and execute are decoupled by a small instruction queue, so neither one waits on the other. Each fetch request goes to a memory controller. The request address is the program counter, with a 4-bit code-segment base placed above it. Two requests may be in flight at once, and the memory returns responses in the order the requests were accepted.

The execute stage takes the instruction at the head of the queue, together with the program counter of that instruction. On the last cycle of the instruction it pulses a completion strobe, and the unit then drops the head entry. The execute stage raises a redirect with a new program counter for a taken branch, a code-segment reload or a halt. The redirect empties the queue and marks every in-flight request as stale. Fetching then restarts at the new address. Data that arrives later for a stale request is dropped.

Top module: `ifetch_queue`

## Requirements
- R1: At most two fetch requests are outstanding at any time. A request counts as outstanding from the cycle in which `mem_req` and `mem_gnt` are both high until the cycle in which its `mem_rvalid` arrives.
- R2: The queue holds four instructions. A request is raised only while the queued instructions plus the live outstanding requests number fewer than four. With the queue stalled and the memory always granting, exactly four requests are accepted after a redirect, and then `mem_req` stays low.
- R3: `mem_addr` is `{cseg_base, pc}`, with the segment base in bits 19:16 and the 16-bit program counter in bits 15:0. The program counter advances by 2 for each accepted request.
- R4: `ins_valid` is high while the queue is not empty. Instructions leave the queue in request order. `ins_word` is the returned data, and `ins_pc` is the address at which it was fetched.
- R5: When `exec_done` is high and `ins_valid` is high, the head entry is removed at the next clock edge. When the queue is empty, `exec_done` has no effect.
- R6: `mem_req` is low in a cycle where `redirect` is high. In the cycle after it, `ins_valid` is low. The next accepted request uses `redirect_pc`.
- R7: Responses to requests issued before a redirect never enter the queue.
- R8: With a memory that grants every cycle and answers one cycle later, and `exec_done` held high, one instruction completes every cycle once the pipe is full.
- R9: After reset, `ins_valid` is low and `mem_req` is high at `{cseg_base, 16'h0000}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cseg_base | input | 4 | Code-segment base, forms address bits 19:16 |
| redirect | input | 1 | Flush and restart fetch |
| redirect_pc | input | 16 | Program counter to restart at |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | 20 | Fetch byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | In-order response valid |
| mem_rdata | input | 16 | Response instruction word |
| ins_valid | output | 1 | Head instruction present |
| ins_word | output | 16 | Head instruction |
| ins_pc | output | 16 | Program counter of head instruction |
| exec_done | input | 1 | Head instruction completes |

## Verification
If the live-request bookkeeping goes wrong, a stale word shows up at the head of the queue. The bench catches this on the first instruction the execute stage takes after a redirect, because `ins_pc` or `ins_word` then differs from the stream expected from `redirect_pc`. If the program counter or the credit count goes wrong, it shows in the first accepted request with a wrong address, or as a fifth grant while the queue is stalled. If the outstanding count drifts, the bench's in-flight count reaches three, or throughput drops below one instruction per cycle within a few cycles of the pipe filling. The sweeps cover memory latency, grant patterns and completion patterns, with redirects landing at arbitrary points.

// File: rtl/ifetch_queue.sv
module ifetch_queue #(
  parameter int QDEPTH = 4,
  parameter int MAXOUT = 2,
  parameter int PC_W = 16,
  parameter int SEG_W = 4,
  parameter int INS_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEG_W-1:0]   cseg_base,
  input  logic               redirect,
  input  logic [PC_W-1:0]    redirect_pc,
  output logic               mem_req,
  output logic [SEG_W+PC_W-1:0] mem_addr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [INS_W-1:0]   mem_rdata,
  output logic               ins_valid,
  output logic [INS_W-1:0]   ins_word,
  output logic [PC_W-1:0]    ins_pc,
  input  logic               exec_done
);
  localparam int QPTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int SPTR_W = (MAXOUT > 1) ? $clog2(MAXOUT) : 1;
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int SCNT_W = $clog2(MAXOUT + 1);

  logic [PC_W-1:0]   pc;
  logic [INS_W-1:0]  q_word [QDEPTH];
  logic [PC_W-1:0]   q_pc   [QDEPTH];
  logic [QPTR_W-1:0] q_rd, q_wr;
  logic [CNT_W-1:0]  q_cnt;
  logic [PC_W-1:0]   s_pc   [MAXOUT];
  logic [MAXOUT-1:0] s_live, s_live_nxt;
  logic [SPTR_W-1:0] s_rd, s_wr;
  logic [SCNT_W-1:0] s_cnt;
  logic              issue, resp, resp_live, deq, credit;

  function automatic logic [QPTR_W-1:0] q_next(input logic [QPTR_W-1:0] p);
    return (p == QPTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SPTR_W-1:0] s_next(input logic [SPTR_W-1:0] p);
    return (p == SPTR_W'(MAXOUT - 1)) ? '0 : p + 1'b1;
  endfunction

  assign credit    = (int'(q_cnt) + $countones(s_live)) < QDEPTH;
  assign mem_req   = rst_n && !redirect && (int'(s_cnt) < MAXOUT) && credit;
  assign mem_addr  = {cseg_base, pc};
  assign issue     = mem_req && mem_gnt;
  assign resp      = mem_rvalid;
  assign resp_live = mem_rvalid && s_live[s_rd] && !redirect;
  assign ins_valid = q_cnt != '0;
  assign deq       = exec_done && ins_valid && !redirect;
  assign ins_word  = q_word[q_rd];
  assign ins_pc    = q_pc[q_rd];

  always_comb begin
    s_live_nxt = s_live;
    if (resp)     s_live_nxt[s_rd] = 1'b0;
    if (issue)    s_live_nxt[s_wr] = 1'b1;
    if (redirect) s_live_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= RESET_PC;
      q_rd   <= '0;
      q_wr   <= '0;
      q_cnt  <= '0;
      s_rd   <= '0;
      s_wr   <= '0;
      s_cnt  <= '0;
      s_live <= '0;
    end else begin
      s_live <= s_live_nxt;
      s_cnt  <= s_cnt + SCNT_W'(issue) - SCNT_W'(resp);
      if (resp)  s_rd <= s_next(s_rd);
      if (issue) s_wr <= s_next(s_wr);
      if (redirect) begin
        pc    <= redirect_pc;
        q_rd  <= '0;
        q_wr  <= '0;
        q_cnt <= '0;
      end else begin
        if (issue)     pc   <= pc + PC_W'(2);
        if (resp_live) q_wr <= q_next(q_wr);
        if (deq)       q_rd <= q_next(q_rd);
        q_cnt <= q_cnt + CNT_W'(resp_live) - CNT_W'(deq);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (issue) s_pc[s_wr] <= pc;
    if (resp_live) begin
      q_word[q_wr] <= mem_rdata;
      q_pc[q_wr]   <= s_pc[s_rd];
    end
  end
endmodule

module ifetch_queue_chk #(
  parameter int QDEPTH = 4,
  parameter int MAXOUT = 2,
  parameter int PC_W = 16,
  parameter int SEG_W = 4,
  parameter int CNT_W = 3,
  parameter int SCNT_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  redirect,
  input logic [PC_W-1:0]       redirect_pc,
  input logic                  mem_req,
  input logic                  mem_gnt,
  input logic [SEG_W+PC_W-1:0] mem_addr,
  input logic                  ins_valid,
  input logic [CNT_W-1:0]      q_cnt,
  input logic [SCNT_W-1:0]     s_cnt,
  input logic [MAXOUT-1:0]     s_live
);
  a_r1_outstanding_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(s_cnt) < MAXOUT));
  a_r2_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_cnt) + $countones(s_live)) <= QDEPTH);
  a_r2_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_cnt) == QDEPTH) |-> !mem_req);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && mem_gnt) && !$past(redirect) && mem_req)
      |-> mem_addr[PC_W-1:0] == $past(mem_addr[PC_W-1:0]) + PC_W'(2));
  a_r6_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !mem_req);
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !ins_valid);
  a_r6_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(redirect) && mem_req) |-> mem_addr[PC_W-1:0] == $past(redirect_pc));
endmodule

bind ifetch_queue ifetch_queue_chk #(
  .QDEPTH(QDEPTH), .MAXOUT(MAXOUT), .PC_W(PC_W), .SEG_W(SEG_W),
  .CNT_W(CNT_W), .SCNT_W(SCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .ins_valid(ins_valid), .q_cnt(q_cnt), .s_cnt(s_cnt), .s_live(s_live)
);

// File: tb/sim_ifetch_queue.sv
module sim_ifetch_queue;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cseg_base = 4'h7;
  logic        redirect = 1'b0;
  logic [15:0] redirect_pc = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        ins_valid;
  logic [15:0] ins_word;
  logic [15:0] ins_pc;
  logic        exec_done = 1'b0;

  ifetch_queue u0 (
    .clk(clk), .rst_n(rst_n), .cseg_base(cseg_base), .redirect(redirect),
    .redirect_pc(redirect_pc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_word(ins_word), .ins_pc(ins_pc),
    .exec_done(exec_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int lat = 1, gnt_mode = 0, done_mode = 0;
  int gnt_force = -1, done_force = -1;
  bit redir_now = 0;
  logic [15:0] redir_target = '0;
  logic [3:0]  seg_next = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] exp_pc = '0, exp_req_pc = '0, first_pc = '0;
  bit first_seen = 0, prev_redir = 0;
  int grants_since = 0, consumed = 0;
  logic [19:0] mq_addr [8];
  int mq_due [8];
  int mq_h = 0, mq_t = 0, mq_n = 0;

  function automatic logic [15:0] word_of(input logic [19:0] a);
    return {a[7:0], a[15:8]} ^ {12'h000, a[19:16]} ^ 16'h3C00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (gnt_force >= 0) mem_gnt = gnt_force[0];
    else mem_gnt = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? cyc[0] : lfsr[3];
    if (done_force >= 0) exec_done = done_force[0];
    else exec_done = (done_mode == 0) ? 1'b1 : (done_mode == 1) ? cyc[1] : lfsr[7];
    redirect = redir_now;
    redirect_pc = redir_target;
    if (redir_now) cseg_base = seg_next;
    mem_rvalid = (mq_n > 0) && (mq_due[mq_h] <= cyc);
    mem_rdata = mem_rvalid ? word_of(mq_addr[mq_h]) : 16'h0;
    #1;
    if (prev_redir) chk(ins_valid == 1'b0, "R6 valid after flush", ins_valid, 0);
    if (redirect) begin
      chk(mem_req == 1'b0, "R6 req in flush", mem_req, 0);
      exp_pc = redirect_pc;
      exp_req_pc = redirect_pc;
      first_seen = 0;
      grants_since = 0;
    end else begin
      if (mem_req && mem_gnt) begin
        chk(mem_addr == {cseg_base, exp_req_pc}, "R3 address", mem_addr, {cseg_base, exp_req_pc});
        mq_addr[mq_t] = mem_addr;
        mq_due[mq_t] = cyc + lat;
        mq_t = (mq_t + 1) % 8;
        mq_n++;
        exp_req_pc = exp_req_pc + 16'd2;
        grants_since++;
      end
      if (ins_valid && exec_done) begin
        chk(ins_pc == exp_pc, "R4 head pc", ins_pc, exp_pc);
        chk(ins_word == word_of({cseg_base, exp_pc}), "R4 head word", ins_word,
            word_of({cseg_base, exp_pc}));
        if (!first_seen) begin
          first_seen = 1;
          first_pc = ins_pc;
        end
        exp_pc = exp_pc + 16'd2;
        consumed++;
      end
    end
    if (mem_rvalid) begin
      mq_h = (mq_h + 1) % 8;
      mq_n--;
    end
    chk(mq_n <= 2, "R1 outstanding", mq_n, 2);
    prev_redir = redirect;
  endtask

  task automatic flush_to(input logic [15:0] pc, input logic [3:0] seg);
    redir_now = 1;
    redir_target = pc;
    seg_next = seg;
    step();
    redir_now = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ins_valid == 1'b0, "R9 reset valid", ins_valid, 0);
    chk(mem_req == 1'b1, "R9 reset req", mem_req, 1);
    chk(mem_addr == 20'h70000, "R9 reset addr", mem_addr, 20'h70000);

    // R2: stall execute, count accepted requests
    lat = 1; gnt_mode = 0; done_force = 0;
    flush_to(16'h1000, 4'h2);
    repeat (12) step();
    chk(grants_since == 4, "R2 grants while stalled", grants_since, 4);
    chk(mem_req == 1'b0, "R2 req when full", mem_req, 0);
    done_force = -1; done_mode = 0;
    repeat (10) step();

    // R5: completion strobe with empty queue
    gnt_force = 0; done_force = 1;
    flush_to(16'h2468, 4'h3);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(ins_valid == 1'b0, "R5 empty queue", ins_valid, 0);
    end
    gnt_force = -1;
    repeat (8) step();
    chk(first_seen && first_pc == 16'h2468, "R5 first after idle done", first_pc, 16'h2468);

    // R7: stale responses in flight across a redirect
    lat = 3; done_force = 0;
    flush_to(16'h4000, 4'h4);
    repeat (2) step();
    gnt_force = 0;
    flush_to(16'h8000, 4'h9);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(ins_valid == 1'b0, "R7 stale dropped", ins_valid, 0);
    end
    chk(mq_n == 0, "R7 stale drained", mq_n, 0);
    gnt_force = -1; done_force = 1;
    repeat (12) step();
    chk(first_seen && first_pc == 16'h8000, "R7 first after flush", first_pc, 16'h8000);

    // R8: one instruction per cycle
    lat = 1; gnt_mode = 0; done_force = 1;
    flush_to(16'h0100, 4'h1);
    repeat (8) step();
    consumed = 0;
    repeat (32) step();
    chk(consumed == 32, "R8 throughput", consumed, 32);
    done_force = -1;

    // Sweep latency, grant pattern and completion pattern
    for (int l = 1; l <= 3; l++)
      for (int g = 0; g < 3; g++)
        for (int d = 0; d < 3; d++) begin
          lat = l; gnt_mode = g; done_mode = d;
          flush_to({lfsr[15:1], 1'b0}, lfsr[3:0]);
          for (int c = 0; c < 200; c++) begin
            if (c % 29 == 17 || lfsr[9:4] == 6'h2A) flush_to({lfsr[14:0], 1'b0}, lfsr[11:8]);
            else step();
          end
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule